// File: doc/BRIEF.md
# Multichip Sync Stage Sequencer

This block runs the receive-side part of a multichip alignment procedure. A reference pulse train arrives from outside, asynchronous to the local device clock. Each rising edge of that pulse, once it passes the block's qualification, moves a four-step sequence forward. Each step fires a one-cycle strobe toward the clocking logic that the step aligns:

- **Steps one and two** realign the device clock divider.
- **Step three** realigns the high-speed digital dividers.
- **Step four** aligns, in one action, the oscillator phase, the multiframe clock and the RF synthesizer phase.

The first divider realignment makes the clock PLL relock. For that reason the block then ignores every reference edge until a fixed number of PFD reference ticks has passed.

Software raises the enable input to arm the sequence. Raising it clears the stage and the settle counter. Software reads the stage code to see whether the sequence has reached completion, and then drops enable. With enable low, the stage, the done flag and the settle count hold their values and no edges are taken. A free-running reference pulse can therefore stay on after alignment without triggering any further realignment.

Top module: `mcs_stage_seq`

## Requirements
- R1: After reset, stage_o is 0, done_o is 0 and all three strobes are low.
- R2: The reference input passes two synchronizing flops. An edge is a synchronized low followed by a synchronized high on the next cycle. The strobe rises three clock edges after the input goes high, and a reference held high gives only one edge.
- R3: An edge in stage 0 pulses dev_div_sync_o and moves to stage 1 (settle). While in stage 1, edges are ignored. The stage becomes 2 on the clock edge that samples the BLANK_TICKS-th ref_tick_i (default 1024) counted while in stage 1 with enable high.
- R4: An edge in stage 2 pulses dev_div_sync_o again and moves to stage 3.
- R5: An edge in stage 3 pulses hs_div_sync_o and moves to stage 4.
- R6: An edge in stage 4 pulses phase_sync_o, moves to stage 5 and sets done_o. In stage 5, edges give no strobe and the stage stays at 5.
- R7: Each strobe is high for exactly one clock cycle, and at most one strobe is high at a time.
- R8: While enable_i is low, edges give no strobe, ref_tick_i pulses are not counted, and stage_o and done_o keep their values.
- R9: A low-to-high change of enable_i sets stage_o to 0, clears done_o and restarts the settle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle pulse per PFD reference period, in the clk domain |
| sysref_i | input | 1 | Asynchronous reference pulse input |
| enable_i | input | 1 | Software enable; a rising change re-arms the sequence |
| dev_div_sync_o | output | 1 | One-cycle device clock divider realignment strobe |
| hs_div_sync_o | output | 1 | One-cycle high-speed divider realignment strobe |
| phase_sync_o | output | 1 | One-cycle oscillator, multiframe clock and RF synthesizer phase strobe |
| stage_o | output | 3 | Stage code: 0 idle, 1 settle, 2/3/4 awaiting edge two/three/four, 5 done |
| done_o | output | 1 | High once the fourth step has fired |

## Verification
The main sequence is walked with a table of four edges. Each row has a different number of reference ticks before its edge, so the table shows whether the strobe is chosen by the stage or simply by edge count.

The settle window is probed in three ways, which separate an off-by-one count from a missing or ignored window:
- an edge after 1023 ticks, which must be ignored;
- the exact tick at which the stage moves on;
- ticks sent while enable is low, which must not count.

Further edges are sent with enable low, after completion, and after re-arming. These show whether disabling holds the state and whether re-enabling clears it.

// File: rtl/mcs_seq_pkg.sv
package mcs_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BLANK = 3'd1,
        ST_WAIT2 = 3'd2,
        ST_WAIT3 = 3'd3,
        ST_WAIT4 = 3'd4,
        ST_DONE  = 3'd5
    } mcs_stage_e;

    typedef struct packed {
        logic phase_sync;
        logic hs_div;
        logic dev_div;
    } mcs_strobe_t;

    localparam mcs_strobe_t NO_STROBE = '{phase_sync: 1'b0, hs_div: 1'b0, dev_div: 1'b0};

    // A stage that waits for a reference edge
    function automatic logic accepts_edge(mcs_stage_e s);
        return (s == ST_IDLE) || (s == ST_WAIT2) || (s == ST_WAIT3) || (s == ST_WAIT4);
    endfunction

    // Strobe fired when an edge is accepted in stage s
    function automatic mcs_strobe_t strobe_for(mcs_stage_e s);
        mcs_strobe_t r;
        r = NO_STROBE;
        case (s)
            ST_IDLE, ST_WAIT2: r.dev_div    = 1'b1;
            ST_WAIT3:          r.hs_div     = 1'b1;
            ST_WAIT4:          r.phase_sync = 1'b1;
            default:           r = NO_STROBE;
        endcase
        return r;
    endfunction

    // Stage entered after an accepted edge
    function automatic mcs_stage_e next_after_edge(mcs_stage_e s);
        case (s)
            ST_IDLE:  return ST_BLANK;
            ST_WAIT2: return ST_WAIT3;
            ST_WAIT3: return ST_WAIT4;
            ST_WAIT4: return ST_DONE;
            default:  return s;
        endcase
    endfunction

endpackage

// File: rtl/mcs_sysref_edge.sv
module mcs_sysref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sysref_i,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    generate
        if (SYNC_STAGES < 2) begin : g_bad_depth
            initial $error("SYNC_STAGES must be at least 2");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], sysref_i};
        end
    end

    // Synchronized high now, synchronized low one cycle earlier
    assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

endmodule

// File: rtl/mcs_blank_timer.sv
module mcs_blank_timer #(
    parameter int BLANK_TICKS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CNT_W = (BLANK_TICKS < 2) ? 1 : $clog2(BLANK_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign expire_o = run_i & tick_i & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear_i || expire_o) begin
            cnt <= '0;
        end else if (run_i && tick_i) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mcs_stage_fsm.sv
module mcs_stage_fsm
    import mcs_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable_i,
    input  logic        rise_i,
    input  logic        blank_done_i,
    output mcs_stage_e  stage_o,
    output mcs_strobe_t strobe_o,
    output logic        done_o,
    output logic        timer_clear_o,
    output logic        timer_run_o
);
    mcs_stage_e  state_q, state_d;
    mcs_strobe_t strobe_d;
    logic        en_q;
    logic        arm;

    assign arm = enable_i & ~en_q;

    always_comb begin
        state_d  = state_q;
        strobe_d = NO_STROBE;
        if (arm) begin
            state_d = ST_IDLE;
        end else if (enable_i) begin
            if (state_q == ST_BLANK) begin
                if (blank_done_i) begin
                    state_d = ST_WAIT2;
                end
            end else if (rise_i && accepts_edge(state_q)) begin
                strobe_d = strobe_for(state_q);
                state_d  = next_after_edge(state_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            strobe_o <= NO_STROBE;
            done_o   <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_o <= strobe_d;
            done_o   <= (state_d == ST_DONE);
            en_q     <= enable_i;
        end
    end

    assign stage_o       = state_q;
    assign timer_clear_o = arm;
    assign timer_run_o   = enable_i & ~arm & (state_q == ST_BLANK);

endmodule

// File: rtl/mcs_stage_seq.sv
module mcs_stage_seq
    import mcs_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BLANK_TICKS = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick_i,
    input  logic       sysref_i,
    input  logic       enable_i,
    output logic       dev_div_sync_o,
    output logic       hs_div_sync_o,
    output logic       phase_sync_o,
    output logic [2:0] stage_o,
    output logic       done_o
);
    logic        rise;
    logic        blank_done;
    logic        t_clear;
    logic        t_run;
    mcs_stage_e  stage;
    mcs_strobe_t strobe;

    mcs_sysref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .sysref_i (sysref_i),
        .rise_o   (rise)
    );

    mcs_blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (t_clear),
        .run_i    (t_run),
        .tick_i   (ref_tick_i),
        .expire_o (blank_done)
    );

    mcs_stage_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .enable_i      (enable_i),
        .rise_i        (rise),
        .blank_done_i  (blank_done),
        .stage_o       (stage),
        .strobe_o      (strobe),
        .done_o        (done_o),
        .timer_clear_o (t_clear),
        .timer_run_o   (t_run)
    );

    assign stage_o        = stage;
    assign dev_div_sync_o = strobe.dev_div;
    assign hs_div_sync_o  = strobe.hs_div;
    assign phase_sync_o   = strobe.phase_sync;

endmodule

// File: rtl/mcs_stage_seq_chk.sv
module mcs_stage_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable_i,
    input logic       dev_div_sync_o,
    input logic       hs_div_sync_o,
    input logic       phase_sync_o,
    input logic [2:0] stage_o,
    input logic       done_o
);
    logic [2:0] strb;
    assign strb = {phase_sync_o, hs_div_sync_o, dev_div_sync_o};

    // R7: never two strobes together
    a_r7_onehot_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb));

    // R7: a strobe lasts one cycle
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (strb != 3'b000) |=> (strb == 3'b000));

    // R6: done rises only together with the phase strobe
    a_r6_done_with_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> phase_sync_o);

    // R3: no strobe while staying in the settle stage
    a_r3_quiet_in_blank: assert property (@(posedge clk) disable iff (rst)
        (stage_o == 3'd1 && $past(stage_o) == 3'd1) |-> (strb == 3'b000));

    // R8: disabled cycles keep the stage
    a_r8_hold_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> (stage_o == $past(stage_o) && done_o == $past(done_o)));

    // R8: disabled cycles fire nothing
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> (strb == 3'b000));

endmodule

bind mcs_stage_seq mcs_stage_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .enable_i       (enable_i),
    .dev_div_sync_o (dev_div_sync_o),
    .hs_div_sync_o  (hs_div_sync_o),
    .phase_sync_o   (phase_sync_o),
    .stage_o        (stage_o),
    .done_o         (done_o)
);

// File: tb/mcs_stage_seq_tb.sv
module mcs_stage_seq_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       ref_tick_i;
    logic       sysref_i;
    logic       enable_i;
    logic       dev_div_sync_o;
    logic       hs_div_sync_o;
    logic       phase_sync_o;
    logic [2:0] stage_o;
    logic       done_o;

    int n_checks = 0;
    int n_fail   = 0;

    // rows: ticks before edge, expected strobe {phase,hs,dev}, expected stage after
    localparam int VEC [4][3] = '{
        '{0,    1, 1},
        '{1024, 1, 3},
        '{0,    2, 4},
        '{0,    4, 5}
    };

    always #2 clk = ~clk;

    mcs_stage_seq u_dut (
        .clk            (clk),
        .rst            (rst),
        .ref_tick_i     (ref_tick_i),
        .sysref_i       (sysref_i),
        .enable_i       (enable_i),
        .dev_div_sync_o (dev_div_sync_o),
        .hs_div_sync_o  (hs_div_sync_o),
        .phase_sync_o   (phase_sync_o),
        .stage_o        (stage_o),
        .done_o         (done_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int strobes();
        return {phase_sync_o, hs_div_sync_o, dev_div_sync_o};
    endfunction

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick_i = 1'b1;
            @(negedge clk) ref_tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    // raise sysref, sample strobe three edges later and one cycle after that
    task automatic pulse(output int first, output int second);
        @(negedge clk) sysref_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) first = strobes();
        @(negedge clk) second = strobes();
        repeat (3) @(negedge clk);
        sysref_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int s1, s2;
        rst = 1'b1; ref_tick_i = 1'b0; sysref_i = 1'b0; enable_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(stage_o, 0, "R1 stage after reset");
        check(done_o, 0, "R1 done after reset");
        check(strobes(), 0, "R1 strobes after reset");

        // R8: edge while disabled is ignored
        pulse(s1, s2);
        check(s1, 0, "R8 edge while disabled, strobe");
        check(stage_o, 0, "R8 edge while disabled, stage");

        @(negedge clk) enable_i = 1'b1;
        @(negedge clk);

        // table walk: R2 latency, R3..R6 stage order, R7 one cycle
        for (int r = 0; r < 4; r++) begin
            give_ticks(VEC[r][0]);
            pulse(s1, s2);
            check(s1, VEC[r][1], $sformatf("R2/R4/R5/R6 row %0d strobe", r));
            check(s2, 0, $sformatf("R7 row %0d strobe one cycle", r));
            check(stage_o, VEC[r][2], $sformatf("R3/R4/R5/R6 row %0d stage", r));
        end
        check(done_o, 1, "R6 done after fourth edge");

        // R6: edges after done ignored
        pulse(s1, s2);
        check(s1, 0, "R6 edge in done, strobe");
        check(stage_o, 5, "R6 edge in done, stage");

        // R8: disable keeps done state
        @(negedge clk) enable_i = 1'b0;
        pulse(s1, s2);
        check(stage_o, 5, "R8 disabled after done, stage");
        check(done_o, 1, "R8 disabled after done, done");

        // R9: re-enable clears
        @(negedge clk) enable_i = 1'b1;
        @(negedge clk);
        check(stage_o, 0, "R9 re-enable stage");
        check(done_o, 0, "R9 re-enable done");

        // R3: settle window
        pulse(s1, s2);
        check(s1, 1, "R3 first edge strobe");
        check(stage_o, 1, "R3 enter settle");
        give_ticks(1000);
        // R8: ticks while disabled are not counted
        @(negedge clk) enable_i = 1'b0;
        give_ticks(40);
        pulse(s1, s2);
        check(s1, 0, "R8 disabled in settle, strobe");
        check(stage_o, 1, "R8 disabled in settle, stage");
        // re-enable clears count (R9): count restarts from zero
        @(negedge clk) enable_i = 1'b1;
        @(negedge clk);
        check(stage_o, 0, "R9 re-enable from settle");
        pulse(s1, s2);
        check(stage_o, 1, "R3 settle again");
        give_ticks(1023);
        check(stage_o, 1, "R3 still settling after 1023 ticks");
        pulse(s1, s2);
        check(s1, 0, "R3 edge in settle ignored");
        check(stage_o, 1, "R3 stage held in settle");
        give_ticks(1);
        check(stage_o, 2, "R3 settle ends on 1024th tick");

        // R2: a held-high reference gives only one edge
        @(negedge clk) sysref_i = 1'b1;
        repeat (20) @(negedge clk);
        check(stage_o, 3, "R2 held high, one edge only");
        sysref_i = 1'b0;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule